// File: doc/BRIEF.md
# SAR ADC Register Front End

This block is the digital side of a four-input, 8-bit successive-approximation converter in a small microcontroller. Software reaches it through a byte-wide register bus with three addresses: one for the conversion result, one for control and status, and one for the conversion clock choice. The control register also chooses how many of the four port pins act as analog inputs. It then drives a pin mask that turns off the digital function of those pins, and a power enable for the analog circuitry.

A conversion needs a full pulse on the start bit: a write of 1 and then a write of 0. Writing 1 resets the converter and raises the busy flag. Writing 0 launches the conversion. The sequencer sets a trial code on the DAC output, starting from the most significant bit. It samples the external comparator once per conversion clock and keeps or drops each bit. After eight steps it loads the result register in one update, clears the busy flag and raises an interrupt request. The interrupt request is gated by an enable input.

Top module: `adc_sar_frontend`

## Requirements
- R1: Reads are registered and show the addressed register one cycle after the address is presented. 0x21 holds the result, D7 as MSB. 0x22 holds the control register: bits [2:0] channel, [5:3] pin configuration, bit 6 busy flag, bit 7 start. 0x23 holds the clock selection in bits [1:0], and its bits [7:2] always read 0. Writes to 0x21 have no effect. After reset every register reads 0.
- R2: Configuration code k from 1 to 4 gives a pin mask with the low k bits set (0001, 0011, 0111, 1111) and drives the power enable high. Codes 0 and 5 to 7 give mask 0000 and power off. Both outputs follow one cycle after the write.
- R3: A control write that takes start from 0 to 1 sets the busy flag (bit 6) to 1 and returns the sequencer to idle.
- R4: A control write that takes start from 1 to 0 launches a conversion only if the written configuration powers the converter and the written channel code (000 to 011 for inputs 0 to 3) is below the number of analog pins. Otherwise the flag stays 1 and the result is unchanged.
- R5: One cycle after launch the DAC code is 0x80 and the channel output equals the selected channel. Bits are resolved MSB first; a bit is kept when the comparator reports input >= trial code. The final result is therefore the input value.
- R6: Clock selection 00 gives a divide of 2, 01 a divide of 8, and 10 or 11 a divide of 32. The flag clears and the result updates exactly 8·N system clocks after the launch edge.
- R7: A start 0 to 1 write during a conversion aborts it. The flag stays 1, the result keeps its previous value and no interrupt is requested. This also holds when the write lands on the completing edge.
- R8: Completion sets an interrupt pending bit. The interrupt output is the registered AND of pending and the enable input. The acknowledge input clears pending, but completion wins over an acknowledge in the same cycle.
- R9: Writing a powered-down configuration during a conversion aborts it. The flag stays 1 and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Clears the pending interrupt |
| irq | output | 1 | Interrupt request |
| conv_pwr | output | 1 | Analog power enable |
| pin_analog | output | 4 | Per-pin analog mode (digital function off) |
| dac_code | output | 8 | Trial code for the external DAC |
| chan_sel | output | 2 | Analog multiplexer select |
| cmp_in | input | 1 | Comparator: input >= DAC level |

## Verification
Two pairs of events can meet on one clock edge: completion with a start-rise abort, and completion with an interrupt acknowledge. Because the divider restarts at launch, the completing edge is exactly 8·N clocks after launch. The bench counts that many edges and times the abort write or the acknowledge pulse to land on it. For the abort, the flag must remain 1, the result register must keep its old value and no interrupt may appear. For the acknowledge, the interrupt must still be asserted after the collision.

// File: rtl/adc_fe_pkg.sv
package adc_fe_pkg;

  localparam int CHAN_LSB  = 0;
  localparam int CHAN_FW   = 3;
  localparam int CFG_LSB   = 3;
  localparam int CFG_FW    = 3;
  localparam int FLAG_BIT  = 6;
  localparam int START_BIT = 7;
  localparam int CKS_FW    = 2;

  typedef enum logic [CKS_FW-1:0] {
    CKS_DIV_A = 2'b00,
    CKS_DIV_B = 2'b01,
    CKS_DIV_C = 2'b10,
    CKS_RSVD  = 2'b11
  } cks_e;

  // number of pins in analog mode for a configuration code, 0 = powered down
  function automatic int analog_pins(input logic [CFG_FW-1:0] cfg, input int num_ch);
    if (cfg != '0 && int'(cfg) <= num_ch) return int'(cfg);
    return 0;
  endfunction

endpackage

// File: rtl/adc_fe_clkdiv.sv
module adc_fe_clkdiv
  import adc_fe_pkg::*;
#(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic [CKS_FW-1:0] sel,
  output logic              tick
);

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  localparam int DIV_MAX = max3(DIV_A, DIV_B, DIV_C);
  localparam int CNT_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    case (cks_e'(sel))
      CKS_DIV_A: lim = CNT_W'(DIV_A - 1);
      CKS_DIV_B: lim = CNT_W'(DIV_B - 1);
      CKS_DIV_C: lim = CNT_W'(DIV_C - 1);
      default:   lim = CNT_W'(DIV_C - 1);
    endcase
  end

  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst)                           cnt <= '0;
    else if (restart || !run || tick)  cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end

  // R6
  tick_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == '0));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && !tick) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/adc_fe_sar.sv
module adc_fe_sar #(
  parameter int DATA_W = 8,
  parameter int CH_W   = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              kill,
  input  logic              tick,
  input  logic [CH_W-1:0]   chan_in,
  input  logic              cmp_in,
  output logic              busy,
  output logic [DATA_W-1:0] dac_code,
  output logic [CH_W-1:0]   chan_sel,
  output logic [DATA_W-1:0] result,
  output logic              done
);

  localparam int PTR_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] cur_bit;
  logic [DATA_W-1:0] kept;
  logic              finish;

  assign cur_bit = DATA_W'(1) << ptr;
  assign kept    = cmp_in ? dac_code : (dac_code & ~cur_bit);
  assign finish  = busy && tick && (ptr == '0);
  assign done    = finish && !kill;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ptr      <= '0;
      dac_code <= '0;
      chan_sel <= '0;
      result   <= '0;
    end else if (kill) begin
      busy     <= 1'b0;
      ptr      <= '0;
      dac_code <= '0;
    end else if (launch) begin
      busy     <= 1'b1;
      ptr      <= PTR_W'(DATA_W - 1);
      dac_code <= DATA_W'(1) << (DATA_W - 1);
      chan_sel <= chan_in;
    end else if (busy && tick) begin
      if (ptr == '0) begin
        result   <= kept;
        busy     <= 1'b0;
        dac_code <= '0;
      end else begin
        dac_code <= kept | (cur_bit >> 1);
        ptr      <= ptr - 1'b1;
      end
    end
  end

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(result));

  // R5
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> (dac_code == (DATA_W'(1) << (DATA_W - 1))));

  // R9
  kill_idle_chk: assert property (@(posedge clk) disable iff (rst)
    kill |=> !busy);

endmodule

// File: rtl/adc_fe_regs.sv
module adc_fe_regs
  import adc_fe_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter int                NUM_CH    = 4,
  parameter int                CH_W      = 2,
  parameter logic [ADDR_W-1:0] ADDR_RES  = 8'h21,
  parameter logic [ADDR_W-1:0] ADDR_CTL  = 8'h22,
  parameter logic [ADDR_W-1:0] ADDR_CKS  = 8'h23
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] result,
  input  logic              done,
  input  logic              irq_en,
  input  logic              irq_ack,
  output logic              irq,
  output logic              conv_pwr,
  output logic [NUM_CH-1:0] pin_analog,
  output logic [CKS_FW-1:0] cks,
  output logic [CH_W-1:0]   launch_chan,
  output logic              launch,
  output logic              kill
);

  logic [CHAN_FW-1:0] chan_q, new_chan;
  logic [CFG_FW-1:0]  cfg_q, new_cfg, cfg_d;
  logic               start_q, eoc_q, pend_q, new_start;
  logic               ctl_wr, cks_wr, start_rise, start_fall;
  logic               pend_d;
  int                 npins_new, npins_d;
  logic [NUM_CH-1:0]  pins_d;

  assign ctl_wr    = bus_wr && (bus_addr == ADDR_CTL);
  assign cks_wr    = bus_wr && (bus_addr == ADDR_CKS);
  assign new_chan  = bus_wdata[CHAN_LSB +: CHAN_FW];
  assign new_cfg   = bus_wdata[CFG_LSB +: CFG_FW];
  assign new_start = bus_wdata[START_BIT];

  assign start_rise = ctl_wr &&  new_start && !start_q;
  assign start_fall = ctl_wr && !new_start &&  start_q;

  assign cfg_d     = ctl_wr ? new_cfg : cfg_q;
  assign npins_new = analog_pins(new_cfg, NUM_CH);
  assign npins_d   = analog_pins(cfg_d, NUM_CH);

  assign launch      = start_fall && (npins_new != 0) && (int'(new_chan) < npins_new);
  assign launch_chan = new_chan[CH_W-1:0];
  assign kill        = start_rise || (npins_d == 0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_pin
    assign pins_d[g] = (g < npins_d);
  end

  assign pend_d = done ? 1'b1 : (irq_ack ? 1'b0 : pend_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q     <= '0;
      cfg_q      <= '0;
      start_q    <= 1'b0;
      eoc_q      <= 1'b0;
      cks        <= '0;
      pend_q     <= 1'b0;
      irq        <= 1'b0;
      conv_pwr   <= 1'b0;
      pin_analog <= '0;
      bus_rdata  <= '0;
    end else begin
      if (ctl_wr) begin
        chan_q  <= new_chan;
        cfg_q   <= new_cfg;
        start_q <= new_start;
      end
      if (cks_wr) cks <= bus_wdata[CKS_FW-1:0];

      if (start_rise) eoc_q <= 1'b1;
      else if (done)  eoc_q <= 1'b0;

      pend_q     <= pend_d;
      irq        <= pend_d && irq_en;
      conv_pwr   <= (npins_d != 0);
      pin_analog <= pins_d;

      if (bus_addr == ADDR_RES)
        bus_rdata <= result;
      else if (bus_addr == ADDR_CTL)
        bus_rdata <= DATA_W'({start_q, eoc_q, cfg_q, chan_q});
      else if (bus_addr == ADDR_CKS)
        bus_rdata <= DATA_W'(cks);
      else
        bus_rdata <= '0;
    end
  end

  // R3
  flag_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    start_rise |=> eoc_q);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !eoc_q);

  // R8
  irq_pend_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (pend_q && (irq == $past(irq_en))));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(irq_en));

endmodule

// File: rtl/adc_sar_frontend.sv
module adc_sar_frontend
  import adc_fe_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 8,
  parameter int                NUM_CH   = 4,
  parameter logic [ADDR_W-1:0] ADDR_RES = 8'h21,
  parameter logic [ADDR_W-1:0] ADDR_CTL = 8'h22,
  parameter logic [ADDR_W-1:0] ADDR_CKS = 8'h23,
  parameter int                DIV_A    = 2,
  parameter int                DIV_B    = 8,
  parameter int                DIV_C    = 32,
  localparam int               CH_W     = (NUM_CH > 2) ? $clog2(NUM_CH) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_en,
  input  logic              irq_ack,
  output logic              irq,
  output logic              conv_pwr,
  output logic [NUM_CH-1:0] pin_analog,
  output logic [DATA_W-1:0] dac_code,
  output logic [CH_W-1:0]   chan_sel,
  input  logic              cmp_in
);

  logic [DATA_W-1:0] result;
  logic              done, launch, kill, tick, sar_busy;
  logic [CKS_FW-1:0] cks;
  logic [CH_W-1:0]   launch_chan;

  adc_fe_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_W(CH_W),
    .ADDR_RES(ADDR_RES), .ADDR_CTL(ADDR_CTL), .ADDR_CKS(ADDR_CKS)
  ) u_regs (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .result(result), .done(done),
    .irq_en(irq_en), .irq_ack(irq_ack), .irq(irq),
    .conv_pwr(conv_pwr), .pin_analog(pin_analog),
    .cks(cks), .launch_chan(launch_chan), .launch(launch), .kill(kill)
  );

  adc_fe_clkdiv #(
    .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)
  ) u_div (
    .clk(clk), .rst(rst), .run(sar_busy), .restart(launch), .sel(cks), .tick(tick)
  );

  adc_fe_sar #(
    .DATA_W(DATA_W), .CH_W(CH_W)
  ) u_sar (
    .clk(clk), .rst(rst), .launch(launch), .kill(kill), .tick(tick),
    .chan_in(launch_chan), .cmp_in(cmp_in),
    .busy(sar_busy), .dac_code(dac_code), .chan_sel(chan_sel),
    .result(result), .done(done)
  );

  // R2
  pwr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !conv_pwr |-> !sar_busy);

endmodule

// File: tb/sim_adc_sar_frontend.sv
module sim_adc_sar_frontend;

  localparam logic [7:0] A_RES = 8'h21;
  localparam logic [7:0] A_CTL = 8'h22;
  localparam logic [7:0] A_CKS = 8'h23;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_en = 1'b0;
  logic       irq_ack = 1'b0;
  logic       irq;
  logic       conv_pwr;
  logic [3:0] pin_analog;
  logic [7:0] dac_code;
  logic [1:0] chan_sel;
  logic       cmp_in;
  logic [7:0] ain [4];

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  assign cmp_in = (ain[chan_sel] >= dac_code);

  adc_sar_frontend u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_en(irq_en),
    .irq_ack(irq_ack), .irq(irq), .conv_pwr(conv_pwr), .pin_analog(pin_analog),
    .dac_code(dac_code), .chan_sel(chan_sel), .cmp_in(cmp_in)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl_word(input bit st, input int cfg, input int ch);
    return {st, 1'b0, 3'(cfg), 3'(ch)};
  endfunction

  function automatic int div_of(input int sel);
    if (sel == 0) return 2;
    if (sel == 1) return 8;
    return 32;
  endfunction

  function automatic logic [3:0] mask_of(input int cfg);
    if (cfg >= 1 && cfg <= 4) return 4'((1 << cfg) - 1);
    return 4'h0;
  endfunction

  // called at a negedge; the write lands on the next posedge
  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic start_conv(input int cfg, input int ch);
    bus_write(A_CTL, ctl_word(1'b1, cfg, ch));
    bus_write(A_CTL, ctl_word(1'b0, cfg, ch));
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (bus_rdata[6] == 1'b0) break;
    end
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int cyc, prev_res, sel, cfg, ch, en;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 4; i++) ain[i] = 8'h00;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    bus_read(A_RES, rd); check(rd == 0, "R1 reset result", rd, 0);
    bus_read(A_CTL, rd); check(rd == 0, "R1 reset control", rd, 0);
    bus_read(A_CKS, rd); check(rd == 0, "R1 reset clock select", rd, 0);
    check(irq == 0 && conv_pwr == 0 && pin_analog == 0 && dac_code == 0,
          "R1 reset outputs", {irq, conv_pwr, pin_analog}, 0);

    // R1 clock-select readback mask and read-only result
    bus_write(A_CKS, 8'hFF);
    bus_read(A_CKS, rd); check(rd == 8'h03, "R1 clock select upper bits", rd, 3);
    bus_write(A_RES, 8'h5A);
    bus_read(A_RES, rd); check(rd == 8'h00, "R1 result write ignored", rd, 0);

    // R2 configuration decode
    for (int c = 0; c < 8; c++) begin
      bus_write(A_CTL, ctl_word(1'b0, c, 0));
      check(pin_analog == mask_of(c), "R2 pin mask", pin_analog, mask_of(c));
      check(conv_pwr == (c >= 1 && c <= 4), "R2 power enable", conv_pwr, (c >= 1 && c <= 4));
    end

    // R3 flag rises; R4 launch refused when powered down
    bus_write(A_CKS, 8'h00);
    bus_write(A_CTL, ctl_word(1'b1, 0, 0));
    bus_read(A_CTL, rd); check(rd[6] == 1, "R3 flag after start rise", rd[6], 1);
    bus_write(A_CTL, ctl_word(1'b0, 0, 0));
    repeat (60) @(negedge clk);
    bus_read(A_CTL, rd); check(rd[6] == 1, "R4 no launch when powered down", rd[6], 1);
    bus_read(A_RES, rd); check(rd == 0, "R4 result unchanged", rd, 0);

    // R4 channel not among analog pins
    ain[2] = 8'h77;
    start_conv(1, 2);
    repeat (60) @(negedge clk);
    bus_read(A_CTL, rd); check(rd[6] == 1, "R4 no launch on non-analog channel", rd[6], 1);
    check(dac_code == 0, "R4 DAC idle", dac_code, 0);

    // R5 R6 R8 random conversions with directed extremes first
    prev_res = 0;
    for (int it = 0; it < 24; it++) begin
      sel = (it < 4) ? it : int'($urandom % 4);
      cfg = (it < 2) ? 4 : 1 + int'($urandom % 4);
      ch  = (it < 2) ? 3 : int'($urandom % cfg);
      en  = int'($urandom % 2);
      for (int k = 0; k < 4; k++) ain[k] = 8'($urandom);
      if (it == 0) ain[ch] = 8'h00;
      if (it == 1) ain[ch] = 8'hFF;
      irq_en = en[0];
      bus_write(A_CKS, 8'(sel));
      start_conv(cfg, ch);
      check(dac_code == 8'h80, "R5 first trial code", dac_code, 8'h80);
      check(chan_sel == 2'(ch), "R5 channel select", chan_sel, ch);
      wait_done(cyc);
      check(cyc == 8 * div_of(sel) + 1, "R6 conversion length", cyc, 8 * div_of(sel) + 1);
      check(irq == en[0], "R8 irq gated by enable", irq, en);
      bus_read(A_RES, rd); check(rd == ain[ch], "R5 result value", rd, ain[ch]);
      prev_res = int'(rd);
      if (en == 0) begin
        irq_en = 1'b1;
        @(negedge clk);
        check(irq == 1, "R8 pending kept while disabled", irq, 1);
      end
      pulse_ack();
      check(irq == 0, "R8 ack clears", irq, 0);
      bus_addr = A_CTL;
    end

    // R7 abort mid conversion
    irq_en = 1'b1;
    bus_write(A_CKS, 8'h01);
    ain[0] = 8'(prev_res ^ 8'hA5);
    start_conv(4, 0);
    repeat (20) @(negedge clk);
    bus_write(A_CTL, ctl_word(1'b1, 4, 0));
    repeat (100) @(negedge clk);
    bus_read(A_CTL, rd); check(rd[6] == 1, "R7 flag stays set after abort", rd[6], 1);
    bus_read(A_RES, rd); check(rd == prev_res, "R7 result kept after abort", rd, prev_res);
    check(irq == 0, "R7 no irq after abort", irq, 0);

    // R7 abort landing on the completing edge
    bus_write(A_CKS, 8'h00);
    ain[1] = 8'(prev_res ^ 8'h3C);
    start_conv(4, 1);
    repeat (15) @(negedge clk);
    bus_write(A_CTL, ctl_word(1'b1, 4, 1));
    repeat (4) @(negedge clk);
    bus_read(A_CTL, rd); check(rd[6] == 1, "R7 collision flag", rd[6], 1);
    bus_read(A_RES, rd); check(rd == prev_res, "R7 collision result kept", rd, prev_res);
    check(irq == 0, "R7 collision no irq", irq, 0);

    // R8 acknowledge on the completing edge
    ain[2] = 8'h9B;
    start_conv(4, 2);
    repeat (15) @(negedge clk);
    pulse_ack();
    check(irq == 1, "R8 completion beats ack", irq, 1);
    bus_read(A_RES, rd); check(rd == 8'h9B, "R8 result on collision", rd, 8'h9B);
    prev_res = int'(rd);
    pulse_ack();

    // R9 power-down mid conversion
    bus_write(A_CKS, 8'h02);
    ain[0] = 8'h11;
    start_conv(3, 0);
    repeat (10) @(negedge clk);
    bus_write(A_CTL, ctl_word(1'b0, 0, 0));
    repeat (300) @(negedge clk);
    bus_read(A_CTL, rd); check(rd[6] == 1, "R9 flag after power-down", rd[6], 1);
    bus_read(A_RES, rd); check(rd == prev_res, "R9 result kept", rd, prev_res);
    check(irq == 0 && conv_pwr == 0, "R9 idle outputs", {irq, conv_pwr}, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule